// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Used-Bit Replacement

This block caches page mappings for an address translation path. Each of its entries maps one fixed-size 8 KiB virtual page to a physical page number. The entry is tagged by the virtual page number, an address-space context number, a partition number and a flag that marks real (untranslated) addresses. A lookup port compares a request against every entry in the same cycle and returns hit, entry index and physical page number. An insert port writes a new mapping at the end of the cycle.

A per-entry used bit picks the slot to replace. A lookup hit marks its entry as used. An insert takes the lowest-numbered slot that is empty or not marked used. When a hit or an insert would leave every used bit set, all used bits are cleared except the one just touched. An insert first removes any valid entry that carries the same tag, so no two valid entries ever answer one lookup.

Top module: `tlb_assoc`

## Requirements
- R1: A lookup hits only when lkp_valid_i is high and some valid entry has an equal virtual page number, context number, partition number and real flag. A difference in any one of the four fields gives a miss.
- R2: On a hit, lkp_idx_o holds the index of the matching entry and lkp_ppn_o holds its stored physical page number, in the same cycle as the request. On a miss, lkp_hit_o is low.
- R3: An insert writes the lowest-indexed entry that is either invalid or has its used bit clear. If no such entry exists, it writes entry 0.
- R4: An insert invalidates every valid entry whose tag equals the new tag and clears that entry's used bit, before it writes the new mapping. At most one valid entry matches any tag.
- R5: A lookup hit with no insert in the same cycle sets the used bit of the matched entry. That entry is then skipped by later victim selection.
- R6: When an update would leave all used bits set, every used bit is cleared except the one of the entry just hit or just inserted.
- R7: Reset (rst_ni low, asynchronous) clears every valid and used bit, so every lookup after reset misses.
- R8: When a lookup and an insert arrive in the same cycle, the insert wins. The lookup outputs reflect the contents before the insert, and the lookup does not change any used bit.
- R9: An inserted mapping sets its entry's valid and used bits and is returned by a lookup from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VA_W-PAGE_BITS | Lookup virtual page number |
| lkp_ctx_i | input | CTX_W | Lookup context number |
| lkp_part_i | input | PART_W | Lookup partition number |
| lkp_real_i | input | 1 | Lookup real-address flag |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_idx_o | output | $clog2(NUM_ENTRIES) | Index of the hit entry |
| lkp_ppn_o | output | PPN_W | Physical page number of the hit entry |
| ins_valid_i | input | 1 | Insert request |
| ins_vpn_i | input | VA_W-PAGE_BITS | Insert virtual page number |
| ins_ctx_i | input | CTX_W | Insert context number |
| ins_part_i | input | PART_W | Insert partition number |
| ins_real_i | input | 1 | Insert real-address flag |
| ins_ppn_i | input | PPN_W | Insert physical page number |

## Verification
The assertions assume that insert and lookup inputs are stable across each rising edge. They also assume that the only way state changes is through inserts, hits and reset, which gives the invariants that used implies valid and that at most one entry matches. The victim-selection property is checked only when some entry is free or unused, because the fallback case cannot occur once the global clear is in place. The stimulus changes inputs one nanosecond after each rising edge. It draws tags from a narrow space of pages, contexts and partitions, so that duplicate inserts, demaps and global clears happen often. This keeps the stream within those assumptions while still reaching the corner cases.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_ENTRIES   = 16;
  localparam int unsigned DEF_VA_W      = 64;
  localparam int unsigned DEF_PAGE_BITS = 13;
  localparam int unsigned DEF_CTX_W     = 13;
  localparam int unsigned DEF_PART_W    = 8;
  localparam int unsigned DEF_PPN_W     = 28;

  typedef enum logic [1:0] {
    UPD_NONE   = 2'd0,
    UPD_LOOKUP = 2'd1,
    UPD_INSERT = 2'd2
  } upd_src_e;
endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
  parameter int unsigned N      = 16,
  parameter int unsigned VPN_W  = 51,
  parameter int unsigned CTX_W  = 13,
  parameter int unsigned PART_W = 8
) (
  input  logic [N-1:0]             valid_i,
  input  logic [N-1:0][VPN_W-1:0]  vpn_i,
  input  logic [N-1:0][CTX_W-1:0]  ctx_i,
  input  logic [N-1:0][PART_W-1:0] part_i,
  input  logic [N-1:0]             real_i,
  input  logic [VPN_W-1:0]         q_vpn_i,
  input  logic [CTX_W-1:0]         q_ctx_i,
  input  logic [PART_W-1:0]        q_part_i,
  input  logic                     q_real_i,
  output logic [N-1:0]             match_o
);
  for (genvar e = 0; e < N; e++) begin : g_cmp
    assign match_o[e] = valid_i[e]
                      && (vpn_i[e]  == q_vpn_i)
                      && (ctx_i[e]  == q_ctx_i)
                      && (part_i[e] == q_part_i)
                      && (real_i[e] == q_real_i);
  end
endmodule

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int unsigned N     = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vec_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_used_ctrl.sv
module tlb_used_ctrl #(
  parameter int unsigned N     = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tlb_pkg::upd_src_e src_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [N-1:0]     clr_mask_i,
  output logic [N-1:0]     used_o
);
  logic [N-1:0] used_q, used_d;

  always_comb begin
    used_d = used_q;
    if (src_i == tlb_pkg::UPD_INSERT) used_d = used_d & ~clr_mask_i;
    if (src_i != tlb_pkg::UPD_NONE) begin
      used_d[set_idx_i] = 1'b1;
      // saturation: keep only the entry just touched
      if (&used_d) begin
        used_d            = '0;
        used_d[set_idx_i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) used_q <= '0;
    else         used_q <= used_d;
  end

  assign used_o = used_q;
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
  parameter int unsigned NUM_ENTRIES = tlb_pkg::DEF_ENTRIES,
  parameter int unsigned VA_W        = tlb_pkg::DEF_VA_W,
  parameter int unsigned PAGE_BITS   = tlb_pkg::DEF_PAGE_BITS,
  parameter int unsigned CTX_W       = tlb_pkg::DEF_CTX_W,
  parameter int unsigned PART_W      = tlb_pkg::DEF_PART_W,
  parameter int unsigned PPN_W       = tlb_pkg::DEF_PPN_W,
  localparam int unsigned VPN_W      = VA_W - PAGE_BITS,
  localparam int unsigned IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic [CTX_W-1:0]  lkp_ctx_i,
  input  logic [PART_W-1:0] lkp_part_i,
  input  logic              lkp_real_i,
  output logic              lkp_hit_o,
  output logic [IDX_W-1:0]  lkp_idx_o,
  output logic [PPN_W-1:0]  lkp_ppn_o,
  input  logic              ins_valid_i,
  input  logic [VPN_W-1:0]  ins_vpn_i,
  input  logic [CTX_W-1:0]  ins_ctx_i,
  input  logic [PART_W-1:0] ins_part_i,
  input  logic              ins_real_i,
  input  logic [PPN_W-1:0]  ins_ppn_i
);
  logic [NUM_ENTRIES-1:0]             valid_q;
  logic [NUM_ENTRIES-1:0]             used_q;
  logic [NUM_ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [NUM_ENTRIES-1:0][CTX_W-1:0]  ctx_q;
  logic [NUM_ENTRIES-1:0][PART_W-1:0] part_q;
  logic [NUM_ENTRIES-1:0]             real_q;
  logic [NUM_ENTRIES-1:0][PPN_W-1:0]  ppn_q;

  logic [NUM_ENTRIES-1:0] lkp_match, ins_match, free_vec;
  logic                   lkp_found, victim_found;
  logic [IDX_W-1:0]       lkp_idx, victim_raw, victim_idx;
  tlb_pkg::upd_src_e      upd_src;
  logic [IDX_W-1:0]       upd_idx;

  // lookup side
  tlb_tag_cmp #(.N(NUM_ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W), .PART_W(PART_W)) u_lkp_cmp (
    .valid_i (valid_q), .vpn_i (vpn_q), .ctx_i (ctx_q), .part_i (part_q), .real_i (real_q),
    .q_vpn_i (lkp_vpn_i), .q_ctx_i (lkp_ctx_i), .q_part_i (lkp_part_i), .q_real_i (lkp_real_i),
    .match_o (lkp_match)
  );

  tlb_first_set #(.N(NUM_ENTRIES)) u_lkp_enc (
    .vec_i (lkp_match), .found_o (lkp_found), .idx_o (lkp_idx)
  );

  assign lkp_hit_o = lkp_valid_i & lkp_found;
  assign lkp_idx_o = lkp_hit_o ? lkp_idx : '0;
  assign lkp_ppn_o = lkp_hit_o ? ppn_q[lkp_idx] : '0;

  // insert side: conflict detect and victim select
  tlb_tag_cmp #(.N(NUM_ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W), .PART_W(PART_W)) u_ins_cmp (
    .valid_i (valid_q), .vpn_i (vpn_q), .ctx_i (ctx_q), .part_i (part_q), .real_i (real_q),
    .q_vpn_i (ins_vpn_i), .q_ctx_i (ins_ctx_i), .q_part_i (ins_part_i), .q_real_i (ins_real_i),
    .match_o (ins_match)
  );

  assign free_vec = ~valid_q | ~used_q;

  tlb_first_set #(.N(NUM_ENTRIES)) u_victim_enc (
    .vec_i (free_vec), .found_o (victim_found), .idx_o (victim_raw)
  );

  assign victim_idx = victim_found ? victim_raw : '0;

  // used-bit bookkeeping; insert takes priority over a lookup hit
  always_comb begin
    upd_src = tlb_pkg::UPD_NONE;
    upd_idx = lkp_idx;
    if (ins_valid_i) begin
      upd_src = tlb_pkg::UPD_INSERT;
      upd_idx = victim_idx;
    end else if (lkp_hit_o) begin
      upd_src = tlb_pkg::UPD_LOOKUP;
    end
  end

  tlb_used_ctrl #(.N(NUM_ENTRIES)) u_used (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (upd_src),
    .set_idx_i  (upd_idx),
    .clr_mask_i (ins_match),
    .used_o     (used_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (ins_valid_i) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (ins_match[e]) valid_q[e] <= 1'b0;
      end
      valid_q[victim_idx] <= 1'b1;
    end
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_store
    always_ff @(posedge clk_i) begin
      if (ins_valid_i && (victim_idx == IDX_W'(e))) begin
        vpn_q[e]  <= ins_vpn_i;
        ctx_q[e]  <= ins_ctx_i;
        part_q[e] <= ins_part_i;
        real_q[e] <= ins_real_i;
        ppn_q[e]  <= ins_ppn_i;
      end
    end
  end
endmodule

// File: rtl/tlb_assoc_checker.sv
module tlb_assoc_checker #(
  parameter int unsigned N     = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lkp_valid_i,
  input logic             lkp_hit_o,
  input logic             ins_valid_i,
  input logic [N-1:0]     valid_q,
  input logic [N-1:0]     used_q,
  input logic [N-1:0]     lkp_match,
  input logic [IDX_W-1:0] lkp_idx,
  input logic [IDX_W-1:0] victim_idx
);
  assert_hit_needs_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> lkp_valid_i);

  assert_single_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_match));

  assert_demap_clears_used_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (used_q & ~valid_q) == '0);

  assert_victim_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && !(&(valid_q & used_q))) |-> (!valid_q[victim_idx] || !used_q[victim_idx]));

  assert_insert_lands_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i |=> (valid_q[$past(victim_idx)] && used_q[$past(victim_idx)]));

  assert_hit_marks_used_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_hit_o && !ins_valid_i) |=> used_q[$past(lkp_idx)]);

  assert_never_all_used_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&used_q));

  assert_insert_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_valid_i && lkp_hit_o && (lkp_idx != victim_idx) && !used_q[lkp_idx])
      |=> !used_q[$past(lkp_idx)]);
endmodule

bind tlb_assoc tlb_assoc_checker #(.N(NUM_ENTRIES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_valid_i (lkp_valid_i),
  .lkp_hit_o   (lkp_hit_o),
  .ins_valid_i (ins_valid_i),
  .valid_q     (valid_q),
  .used_q      (used_q),
  .lkp_match   (lkp_match),
  .lkp_idx     (lkp_idx),
  .victim_idx  (victim_idx)
);

// File: tb/tlb_assoc_test.sv
`timescale 1ns/1ps
module tlb_assoc_test;
  localparam int N      = 16;
  localparam int VPN_W  = 51;
  localparam int CTX_W  = 13;
  localparam int PART_W = 8;
  localparam int PPN_W  = 28;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lkp_valid = 1'b0;
  logic [VPN_W-1:0]  lkp_vpn = '0;
  logic [CTX_W-1:0]  lkp_ctx = '0;
  logic [PART_W-1:0] lkp_part = '0;
  logic              lkp_real = 1'b0;
  logic              lkp_hit;
  logic [IDX_W-1:0]  lkp_idx;
  logic [PPN_W-1:0]  lkp_ppn;
  logic              ins_valid = 1'b0;
  logic [VPN_W-1:0]  ins_vpn = '0;
  logic [CTX_W-1:0]  ins_ctx = '0;
  logic [PART_W-1:0] ins_part = '0;
  logic              ins_real = 1'b0;
  logic [PPN_W-1:0]  ins_ppn = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  tlb_assoc uut (
    .clk_i (clk), .rst_ni (rst_n),
    .lkp_valid_i (lkp_valid), .lkp_vpn_i (lkp_vpn), .lkp_ctx_i (lkp_ctx),
    .lkp_part_i (lkp_part), .lkp_real_i (lkp_real),
    .lkp_hit_o (lkp_hit), .lkp_idx_o (lkp_idx), .lkp_ppn_o (lkp_ppn),
    .ins_valid_i (ins_valid), .ins_vpn_i (ins_vpn), .ins_ctx_i (ins_ctx),
    .ins_part_i (ins_part), .ins_real_i (ins_real), .ins_ppn_i (ins_ppn)
  );

  // behavioural reference
  bit                m_valid [N];
  bit                m_used  [N];
  logic [VPN_W-1:0]  m_vpn   [N];
  logic [CTX_W-1:0]  m_ctx   [N];
  logic [PART_W-1:0] m_part  [N];
  bit                m_real  [N];
  logic [PPN_W-1:0]  m_ppn   [N];

  function automatic int model_find(logic [VPN_W-1:0] v, logic [CTX_W-1:0] c,
                                    logic [PART_W-1:0] p, bit r);
    for (int e = 0; e < N; e++)
      if (m_valid[e] && m_vpn[e] == v && m_ctx[e] == c && m_part[e] == p && m_real[e] == r)
        return e;
    return -1;
  endfunction

  function automatic void model_saturate(int keep);
    int cnt = 0;
    for (int e = 0; e < N; e++) if (m_used[e]) cnt++;
    if (cnt == N)
      for (int e = 0; e < N; e++) m_used[e] = (e == keep);
  endfunction

  task automatic chk(string req, string what, longint got, longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < N; e++) begin m_valid[e] = 0; m_used[e] = 0; end
    end else begin
      int hit_e;
      hit_e = lkp_valid ? model_find(lkp_vpn, lkp_ctx, lkp_part, lkp_real) : -1;
      chk("R1", "model hit", lkp_hit, hit_e >= 0);
      if (hit_e >= 0) begin
        chk("R2", "model idx", lkp_idx, hit_e);
        chk("R2", "model ppn", lkp_ppn, m_ppn[hit_e]);
      end
      if (ins_valid) begin
        int vic = 0;
        int c;
        for (int e = N - 1; e >= 0; e--) if (!m_valid[e] || !m_used[e]) vic = e;
        c = model_find(ins_vpn, ins_ctx, ins_part, ins_real);
        if (c >= 0) begin m_valid[c] = 0; m_used[c] = 0; end
        m_valid[vic] = 1; m_used[vic] = 1;
        m_vpn[vic] = ins_vpn; m_ctx[vic] = ins_ctx; m_part[vic] = ins_part;
        m_real[vic] = ins_real; m_ppn[vic] = ins_ppn;
        model_saturate(vic);
      end else if (hit_e >= 0) begin
        m_used[hit_e] = 1;
        model_saturate(hit_e);
      end
    end
  end

  logic              r_hit;
  logic [IDX_W-1:0]  r_idx;
  logic [PPN_W-1:0]  r_ppn;

  task automatic set_lkp(logic [VPN_W-1:0] v, logic [CTX_W-1:0] c, logic [PART_W-1:0] p, bit r);
    lkp_valid = 1; lkp_vpn = v; lkp_ctx = c; lkp_part = p; lkp_real = r;
  endtask

  task automatic set_ins(logic [VPN_W-1:0] v, logic [CTX_W-1:0] c, logic [PART_W-1:0] p, bit r,
                         logic [PPN_W-1:0] pp);
    ins_valid = 1; ins_vpn = v; ins_ctx = c; ins_part = p; ins_real = r; ins_ppn = pp;
  endtask

  task automatic finish_cycle();
    @(negedge clk);
    r_hit = lkp_hit; r_idx = lkp_idx; r_ppn = lkp_ppn;
    @(posedge clk); #1;
    lkp_valid = 0; ins_valid = 0;
  endtask

  task automatic do_lkp(logic [VPN_W-1:0] v, logic [CTX_W-1:0] c, logic [PART_W-1:0] p, bit r);
    set_lkp(v, c, p, r); finish_cycle();
  endtask

  task automatic do_ins(logic [VPN_W-1:0] v, logic [PPN_W-1:0] pp);
    set_ins(v, 13'd5, 8'd3, 1'b0, pp); finish_cycle();
  endtask

  // insert a tag and report where it landed
  task automatic ins_and_locate(string req, logic [VPN_W-1:0] v, logic [PPN_W-1:0] pp, int exp_idx);
    do_ins(v, pp);
    do_lkp(v, 13'd5, 8'd3, 1'b0);
    chk(req, "landing hit", r_hit, 1);
    chk(req, "landing idx", r_idx, exp_idx);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R7: empty after reset
    do_lkp(51'h100, 13'd5, 8'd3, 1'b0);
    chk("R7", "miss after reset", r_hit, 0);

    // R9: fill all 16 slots in order
    for (int k = 0; k < N; k++) do_ins(51'h100 + k, 28'h50 + k);
    do_lkp(51'h103, 13'd5, 8'd3, 1'b0);
    chk("R9", "filled hit", r_hit, 1);
    chk("R2", "filled idx", r_idx, 3);
    chk("R2", "filled ppn", r_ppn, 28'h53);

    // R1: each field mismatch misses
    do_lkp(51'h203, 13'd5, 8'd3, 1'b0); chk("R1", "vpn differs", r_hit, 0);
    do_lkp(51'h103, 13'd6, 8'd3, 1'b0); chk("R1", "ctx differs", r_hit, 0);
    do_lkp(51'h103, 13'd5, 8'd4, 1'b0); chk("R1", "part differs", r_hit, 0);
    do_lkp(51'h103, 13'd5, 8'd3, 1'b1); chk("R1", "real differs", r_hit, 0);

    // R6: filling made all used, only 15 kept; R5: entry 3 marked by hit
    ins_and_locate("R6", 51'h300, 28'ha0, 0);
    ins_and_locate("R3", 51'h301, 28'ha1, 1);
    ins_and_locate("R3", 51'h302, 28'ha2, 2);
    ins_and_locate("R5", 51'h303, 28'ha3, 4);

    // R4: re-insert page of entry 7 with new ppn
    do_ins(51'h107, 28'h99);
    do_lkp(51'h107, 13'd5, 8'd3, 1'b0);
    chk("R4", "reinsert idx", r_idx, 5);
    chk("R4", "reinsert ppn", r_ppn, 28'h99);
    ins_and_locate("R3", 51'h304, 28'ha4, 6);
    ins_and_locate("R4", 51'h305, 28'ha5, 7);

    // R8: lookup of entry 9 alongside an insert
    set_lkp(51'h109, 13'd5, 8'd3, 1'b0);
    set_ins(51'h306, 13'd5, 8'd3, 1'b0, 28'ha6);
    finish_cycle();
    chk("R8", "lookup during insert hit", r_hit, 1);
    chk("R8", "lookup during insert idx", r_idx, 9);
    do_lkp(51'h306, 13'd5, 8'd3, 1'b0);
    chk("R8", "insert went to", r_idx, 8);
    ins_and_locate("R8", 51'h307, 28'ha7, 9);

    // R6: fill 10..14, saturation keeps 14, next goes to 0
    for (int k = 0; k < 5; k++) do_ins(51'h310 + k, 28'hb0 + k);
    ins_and_locate("R6", 51'h320, 28'hc0, 0);

    // random traffic on a narrow tag space, compared against the model each cycle
    for (int n = 0; n < 2000; n++) begin
      lkp_valid = $urandom_range(0, 3) != 0;
      lkp_vpn   = 51'($urandom_range(0, 23));
      lkp_ctx   = 13'($urandom_range(0, 1));
      lkp_part  = 8'($urandom_range(0, 1));
      lkp_real  = 1'($urandom_range(0, 1));
      ins_valid = $urandom_range(0, 2) == 0;
      ins_vpn   = 51'($urandom_range(0, 23));
      ins_ctx   = 13'($urandom_range(0, 1));
      ins_part  = 8'($urandom_range(0, 1));
      ins_real  = 1'($urandom_range(0, 1));
      ins_ppn   = 28'($urandom);
      @(posedge clk); #1;
    end
    lkp_valid = 0; ins_valid = 0;

    // R7: reset mid-run empties the buffer
    rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    do_lkp(51'h320, 13'd5, 8'd3, 1'b0);
    chk("R7", "miss after second reset", r_hit, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule